// File: doc/BRIEF.md
# Phase Detector and Pump Command Controller

This block compares a divided reference edge with a divided feedback edge and turns their phase difference into up and down pump commands for an external charge pump. Each input edge arrives as a one-cycle strobe on the system clock. Two state flags record which edge came first. When both flags are set, they stay set for a fixed number of cycles before both clear, so that a loop in lock still sees short pulses on both outputs and has no dead zone. Because a flag stays set until the other edge arrives, the compare window spans a full period either way.

Mode pins shape what the pump sees:
- **Polarity:** chooses which flag drives "up".
- **Tri-state:** quiets both commands and drops the drive enable.
- **Current level:** selects the high or the quarter-level pump current.
- **Fast-lock:** when on and the current level is high, the controller pulls an open-drain switch output low so that an external second damping resistor is switched in.

The current level and the fast-lock switch change state only while the pump is idle, so a change never cuts through a pulse. A powerdown request likewise waits for an idle pump before it takes hold. It then freezes the detector and ignores the edge inputs.

A lock monitor counts consecutive comparisons whose pulse width stays within a window. The lock output is high while the loop is locked, drops low during each pump pulse, and is held low when disabled. All pins are plain level or strobe signals; there is no data stream and no handshake.

Top module: `pfd_cp_ctrl`

## Requirements
- R1: After reset `pump_up_o`, `pump_dn_o` and `lock_o` are 0, and `fl_sw_n_o` is 1.
- R2: With `pol_pos_i`=1 and a reference strobe k cycles ahead of the feedback strobe, `pump_up_o` is high for k+RST_DLY cycles and `pump_dn_o` for RST_DLY cycles.
- R3: With `pol_pos_i`=0 the roles swap: the flag set by the reference drives `pump_dn_o`, and the flag set by the feedback drives `pump_up_o`.
- R4: Aligned strobes give pulses of exactly RST_DLY cycles on both outputs. The two outputs are never high together for more than RST_DLY cycles.
- R5: While `tri_i`=1, `pump_up_o`, `pump_dn_o` and `pump_oe_o` are 0.
- R6: `cur_hi_o` takes the value of `cur_hi_i` only in cycles where the detector is idle. While a pulse is active it keeps its previous value.
- R7: `fl_sw_n_o` goes low when `fl_mode_i`=1 and `cur_hi_i`=1. It returns high after the current bit clears. Either change happens only while the detector is idle.
- R8: A powerdown request raised while a pulse is active leaves the pump driving. Powerdown (`pump_oe_o`=0, commands 0) starts only once the detector is idle.
- R9: With `lock_en_i`=1, `lock_o` goes high after `lock_cycles_i` consecutive comparisons whose widest pulse is at most LOCK_WIN cycles. It is low during each pulse. One wider comparison clears the lock.
- R10: With `lock_en_i`=0, `lock_o` is 0.
- R11: Strobes that arrive during powerdown are ignored: after release, no pulse is pending and the next aligned pair gives RST_DLY-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_edge_i | input | 1 | One-cycle strobe from the divided reference |
| fb_edge_i | input | 1 | One-cycle strobe from the divided feedback |
| pol_pos_i | input | 1 | 1: a leading reference drives up; 0: roles swapped |
| tri_i | input | 1 | 1: pump commands held inactive and drive enable low |
| cur_hi_i | input | 1 | 1: high pump current; 0: quarter current |
| fl_mode_i | input | 1 | Fast-lock mode enable |
| pd_req_i | input | 1 | Powerdown request |
| lock_en_i | input | 1 | Enables the lock output |
| lock_cycles_i | input | LCW | Consecutive in-window comparisons needed for lock |
| pump_up_o | output | 1 | Pump-up command |
| pump_dn_o | output | 1 | Pump-down command |
| pump_oe_o | output | 1 | Pump drive enable (0 = high impedance) |
| cur_hi_o | output | 1 | Current level applied to the pump |
| fl_sw_n_o | output | 1 | Open-drain fast-lock resistor switch, active low |
| lock_o | output | 1 | Lock indicator |

## Verification
The bench sweeps leading, lagging and aligned strobe pairs under both polarities and measures pulse widths.
- A design whose clear path ignores its delay would produce one-cycle aligned pulses.
- A design with the polarity swap wired backwards would report the widths on the wrong outputs.

The bench parks the detector on a lone reference strobe. It then raises powerdown and drops the current bit, and checks that none of these changes takes effect before the feedback strobe closes the pulse. An eager implementation would cut off the pump mid-pulse or move the resistor switch mid-pulse.

It also feeds strobes during powerdown and checks that no stale pulse appears after release. Finally it builds lock from a count of clean comparisons and breaks it with one wide comparison.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic pol_pos;
    logic tri_st;
    logic cur_hi;
    logic fl_mode;
    logic pd_req;
  } pfd_mode_t;
endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int RST_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_edge,
  input  logic fb_edge,
  input  logic hold,
  output logic ref_q,
  output logic fb_q
);
  localparam int CW = $clog2(RST_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_DLY - 1);

  logic [CW-1:0] dly_cnt;
  logic both, clr;

  assign both = ref_q & fb_q;
  assign clr  = both & (dly_cnt == LAST);

  // Each flag is set by its own edge; both clear together after the overlap delay.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= 1'b0;
      fb_q    <= 1'b0;
      dly_cnt <= '0;
    end else if (hold) begin
      ref_q   <= 1'b0;
      fb_q    <= 1'b0;
      dly_cnt <= '0;
    end else begin
      ref_q   <= ref_edge | (ref_q & ~clr);
      fb_q    <= fb_edge | (fb_q & ~clr);
      dly_cnt <= (clr || !both) ? '0 : dly_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pump_gate.sv
module pump_gate
  import pfd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pfd_mode_t mode,
  input  logic      ref_q,
  input  logic      fb_q,
  output logic      up,
  output logic      dn,
  output logic      oe,
  output logic      cur_hi,
  output logic      fl_sw_n,
  output logic      pd_act
);
  logic busy, drive, fl_q, cur_q;

  assign busy = ref_q | fb_q;

  // Powerdown only latches in while idle; it releases as soon as the request drops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_act <= 1'b0;
    else        pd_act <= mode.pd_req & (pd_act | ~busy);
  end

  // Current level and resistor switch move only between pulses.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q  <= 1'b0;
      cur_q <= 1'b0;
    end else if (!busy) begin
      fl_q  <= mode.fl_mode & mode.cur_hi;
      cur_q <= mode.cur_hi;
    end
  end

  assign drive   = ~mode.tri_st & ~pd_act;
  assign up      = drive & (mode.pol_pos ? ref_q : fb_q);
  assign dn      = drive & (mode.pol_pos ? fb_q : ref_q);
  assign oe      = drive;
  assign cur_hi  = cur_q;
  assign fl_sw_n = ~fl_q;
endmodule

// File: rtl/lock_mon.sv
module lock_mon #(
  parameter int LOCK_WIN = 3,
  parameter int LCW      = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           busy,
  input  logic           hold,
  input  logic           enable,
  input  logic [LCW-1:0] need,
  output logic           lock
);
  localparam int WW = $clog2(LOCK_WIN + 2);
  localparam logic [WW-1:0] WMAX = '1;
  localparam logic [LCW-1:0] GMAX = '1;

  logic [WW-1:0]  wcnt;
  logic [LCW-1:0] good;
  logic           done, fits, locked;

  assign done = ~busy & (wcnt != '0);
  assign fits = (wcnt <= WW'(LOCK_WIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      good <= '0;
    end else if (hold) begin
      wcnt <= '0;
      good <= '0;
    end else begin
      if (busy) wcnt <= (wcnt == WMAX) ? wcnt : wcnt + 1'b1;
      else      wcnt <= '0;
      if (done) begin
        if (!fits)            good <= '0;
        else if (good != GMAX) good <= good + 1'b1;
      end
    end
  end

  assign locked = (good != '0) && (good >= need);
  assign lock   = enable & locked & ~busy;
endmodule

// File: rtl/pfd_cp_ctrl.sv
module pfd_cp_ctrl
  import pfd_pkg::*;
#(
  parameter int RST_DLY  = 2,
  parameter int LOCK_WIN = 3,
  parameter int LCW      = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_edge_i,
  input  logic           fb_edge_i,
  input  logic           pol_pos_i,
  input  logic           tri_i,
  input  logic           cur_hi_i,
  input  logic           fl_mode_i,
  input  logic           pd_req_i,
  input  logic           lock_en_i,
  input  logic [LCW-1:0] lock_cycles_i,
  output logic           pump_up_o,
  output logic           pump_dn_o,
  output logic           pump_oe_o,
  output logic           cur_hi_o,
  output logic           fl_sw_n_o,
  output logic           lock_o
);
  pfd_mode_t mode;
  logic core_ref_q, core_fb_q, core_busy, pd_act;

  assign mode = '{pol_pos: pol_pos_i, tri_st: tri_i, cur_hi: cur_hi_i,
                  fl_mode: fl_mode_i, pd_req: pd_req_i};
  assign core_busy = core_ref_q | core_fb_q;

  pfd_core #(.RST_DLY(RST_DLY)) u_core (
    .clk(clk), .rst_n(rst_n),
    .ref_edge(ref_edge_i), .fb_edge(fb_edge_i), .hold(pd_act),
    .ref_q(core_ref_q), .fb_q(core_fb_q)
  );

  pump_gate u_gate (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .ref_q(core_ref_q), .fb_q(core_fb_q),
    .up(pump_up_o), .dn(pump_dn_o), .oe(pump_oe_o),
    .cur_hi(cur_hi_o), .fl_sw_n(fl_sw_n_o), .pd_act(pd_act)
  );

  lock_mon #(.LOCK_WIN(LOCK_WIN), .LCW(LCW)) u_lock (
    .clk(clk), .rst_n(rst_n), .busy(core_busy), .hold(pd_act),
    .enable(lock_en_i), .need(lock_cycles_i), .lock(lock_o)
  );
endmodule

// File: rtl/pfd_cp_ctrl_chk.sv
module pfd_cp_ctrl_chk #(
  parameter int RST_DLY = 2
) (
  input logic clk,
  input logic rst_n,
  input logic tri_i,
  input logic pump_up_o,
  input logic pump_dn_o,
  input logic pump_oe_o,
  input logic fl_sw_n_o,
  input logic lock_o,
  input logic ref_q,
  input logic fb_q
);
  logic [7:0] ov_cnt;
  logic busy;
  assign busy = ref_q | fb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ov_cnt <= '0;
    else if (ref_q & fb_q) ov_cnt <= (ov_cnt == 8'hFF) ? ov_cnt : ov_cnt + 1'b1;
    else                   ov_cnt <= '0;
  end

  p_overlap_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ov_cnt <= 8'(RST_DLY));

  p_tristate_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tri_i |-> (!pump_up_o && !pump_dn_o && !pump_oe_o));

  p_fl_switch_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fl_sw_n_o) |-> $past(!busy));

  p_pd_after_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tri_i && $past(!tri_i) && $fell(pump_oe_o)) |-> $past(!busy));

  p_lock_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> !busy);
endmodule

bind pfd_cp_ctrl pfd_cp_ctrl_chk #(.RST_DLY(RST_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .tri_i(tri_i),
  .pump_up_o(pump_up_o), .pump_dn_o(pump_dn_o), .pump_oe_o(pump_oe_o),
  .fl_sw_n_o(fl_sw_n_o), .lock_o(lock_o),
  .ref_q(core_ref_q), .fb_q(core_fb_q)
);

// File: tb/pfd_cp_ctrl_tb_top.sv
module pfd_cp_ctrl_tb_top;
  localparam int RST_DLY = 2;
  localparam int LOCK_WIN = 3;
  localparam int LCW = 4;
  localparam int NV = 8;
  // polarity, offset (>0: reference leads), expected up width, expected down width
  localparam int V_POL[NV] = '{1, 0, 1, 0, 1, 0, 1, 0};
  localparam int V_OFF[NV] = '{3, 3, 0, 0, -4, -4, 6, -1};
  localparam int V_UP [NV] = '{5, 2, 2, 2, 2, 6, 8, 3};
  localparam int V_DN [NV] = '{2, 5, 2, 2, 6, 2, 2, 2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_edge_i = 0, fb_edge_i = 0, pol_pos_i = 1, tri_i = 0;
  logic cur_hi_i = 0, fl_mode_i = 0, pd_req_i = 0, lock_en_i = 0;
  logic [LCW-1:0] lock_cycles_i = 4'd3;
  logic pump_up_o, pump_dn_o, pump_oe_o, cur_hi_o, fl_sw_n_o, lock_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pfd_cp_ctrl #(.RST_DLY(RST_DLY), .LOCK_WIN(LOCK_WIN), .LCW(LCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_edge_i(ref_edge_i), .fb_edge_i(fb_edge_i),
    .pol_pos_i(pol_pos_i), .tri_i(tri_i), .cur_hi_i(cur_hi_i),
    .fl_mode_i(fl_mode_i), .pd_req_i(pd_req_i), .lock_en_i(lock_en_i),
    .lock_cycles_i(lock_cycles_i), .pump_up_o(pump_up_o), .pump_dn_o(pump_dn_o),
    .pump_oe_o(pump_oe_o), .cur_hi_o(cur_hi_o), .fl_sw_n_o(fl_sw_n_o),
    .lock_o(lock_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok || act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    ref_edge_i = 0; fb_edge_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input bit r, input bit f);
    @(negedge clk);
    ref_edge_i = r; fb_edge_i = f;
    @(negedge clk);
    ref_edge_i = 0; fb_edge_i = 0;
  endtask

  task automatic run_pair(input int off, output int nu, output int nd, output int noe);
    int ra, fa;
    ra = (off < 0) ? -off : 0;
    fa = (off > 0) ? off : 0;
    nu = 0; nd = 0; noe = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      nu += int'(pump_up_o);
      nd += int'(pump_dn_o);
      noe += int'(pump_oe_o);
      ref_edge_i = (c == ra);
      fb_edge_i  = (c == fa);
    end
    @(negedge clk);
    ref_edge_i = 0; fb_edge_i = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    int nu, nd, noe;
    do_reset();
    // R1 reset state
    check(1, "R1 up", int'(pump_up_o), 0);
    check(1, "R1 dn", int'(pump_dn_o), 0);
    check(1, "R1 lock", int'(lock_o), 0);
    check(1, "R1 fl_sw_n", int'(fl_sw_n_o), 1);

    // R2 / R3 / R4 vector sweep
    for (int v = 0; v < NV; v++) begin
      pol_pos_i = V_POL[v][0];
      run_pair(V_OFF[v], nu, nd, noe);
      check(1, (V_OFF[v] == 0) ? "R4 up width" : (V_POL[v] == 1 ? "R2 up width" : "R3 up width"), nu, V_UP[v]);
      check(1, (V_OFF[v] == 0) ? "R4 dn width" : (V_POL[v] == 1 ? "R2 dn width" : "R3 dn width"), nd, V_DN[v]);
    end

    // R5 tri-state
    pol_pos_i = 1; tri_i = 1;
    run_pair(3, nu, nd, noe);
    check(1, "R5 up", nu, 0);
    check(1, "R5 dn", nd, 0);
    check(1, "R5 oe", noe, 0);
    tri_i = 0;
    idle(2);

    // R6 / R7 current level and fast-lock held during a pulse
    cur_hi_i = 1; fl_mode_i = 1;
    idle(3);
    check(1, "R7 fl on", int'(fl_sw_n_o), 0);
    check(1, "R6 cur on", int'(cur_hi_o), 1);
    strobe(1, 0);
    cur_hi_i = 0;
    idle(3);
    check(1, "R7 fl held busy", int'(fl_sw_n_o), 0);
    check(1, "R6 cur held busy", int'(cur_hi_o), 1);
    strobe(0, 1);
    idle(5);
    check(1, "R7 fl off", int'(fl_sw_n_o), 1);
    check(1, "R6 cur off", int'(cur_hi_o), 0);
    fl_mode_i = 0;

    // R8 powerdown deferral, R11 ignored strobes
    strobe(1, 0);
    pd_req_i = 1;
    idle(3);
    check(1, "R8 oe kept busy", int'(pump_oe_o), 1);
    check(1, "R8 up kept busy", int'(pump_up_o), 1);
    strobe(0, 1);
    idle(5);
    check(1, "R8 oe off", int'(pump_oe_o), 0);
    strobe(1, 0);
    idle(2);
    check(1, "R11 up in pd", int'(pump_up_o), 0);
    pd_req_i = 0;
    idle(2);
    check(1, "R8 oe back", int'(pump_oe_o), 1);
    check(1, "R11 no stale up", int'(pump_up_o), 0);
    check(1, "R11 no stale dn", int'(pump_dn_o), 0);
    run_pair(0, nu, nd, noe);
    check(1, "R11 aligned up", nu, RST_DLY);
    check(1, "R11 aligned dn", nd, RST_DLY);

    // R9 / R10 lock detect
    do_reset();
    lock_en_i = 1; lock_cycles_i = 4'd3;
    run_pair(0, nu, nd, noe);
    run_pair(0, nu, nd, noe);
    check(1, "R9 not yet", int'(lock_o), 0);
    run_pair(0, nu, nd, noe);
    check(1, "R9 locked", int'(lock_o), 1);
    strobe(1, 1);
    check(1, "R9 low in pulse", int'(lock_o), 0);
    idle(4);
    check(1, "R9 relock", int'(lock_o), 1);
    run_pair(3, nu, nd, noe);
    check(1, "R9 wide clears", int'(lock_o), 0);
    for (int k = 0; k < 3; k++) run_pair(0, nu, nd, noe);
    check(1, "R9 locked again", int'(lock_o), 1);
    lock_en_i = 0;
    idle(1);
    check(1, "R10 disabled", int'(lock_o), 0);

    finish_run();
  end
endmodule